// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a byte-wide serial memory that sits on a two-wire bus, with a clock line driven by the master and an open-drain data line. It watches both lines and finds bus start and stop events. It decodes the address byte, which holds a device-type bit, three select bits compared with strap pins, and the three upper bits of an 11-bit array address. When the address matches, it acknowledges and then accepts single-byte writes or serves sequential reads from a 2048-location register file.

A write is not applied while the bus transfer is in progress. The controller holds the address and data, and a stop condition starts a timed internal write cycle. For the length of that cycle the busy output is high and the controller ignores the bus. The array location is updated when the cycle ends. A read always starts from the internal address pointer. To read a chosen location, the master sends an address-only write followed by a repeated start.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling edge of SDA while SCL is high is a start, and a rising edge of SDA while SCL is high is a stop. A start at any point, including between or inside bytes, begins a new address byte.
- R2: The address byte arrives MSB first as: type bit, S2, S1, S0, A10, A9, A8, R/W. It matches when the type bit is 1, S2 equals `strap_i[2]`, S1 equals the inverse of `strap_i[1]`, and S0 equals `strap_i[0]`. On a match the slave pulls SDA low for the ninth clock. It changes `sda_pull_o` only while SCL is low.
- R3: On a mismatch the slave never pulls SDA until the next start, so every following byte goes unacknowledged.
- R4: When R/W is 0, the next byte is the word address. It is acknowledged and joined below A10..A8 to form the 11-bit internal address. The byte after it is the data byte, and it is acknowledged too.
- R5: An array write is requested only by a stop that follows an acknowledged data byte. A start or stop inside a byte, or a stop after an address-only transfer, leaves the array unchanged and `busy_o` low.
- R6: Once a write is requested, `busy_o` rises within a few cycles of the stop and stays high for exactly `WR_CYCLES` clock cycles. The location is written when the cycle ends.
- R7: While `busy_o` is high, the slave does not acknowledge any address and keeps `sda_pull_o` low.
- R8: When R/W is 1, the slave sends the byte at the internal address, MSB first, and then increments the address, wrapping from 0x7FF to 0x000. The A10..A8 bits of a read address byte are ignored. The pointer is the last word address loaded, advanced by each byte read.
- R9: After the master leaves its acknowledge bit high following a read byte, the slave releases SDA until the next start or stop.
- R10: Any byte after the data byte is not acknowledged. A following stop still commits the first data byte.
- R11: In reset and directly after it, `sda_pull_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Device select straps S2..S0 |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The checks assume a well-behaved bus master. SDA changes only while SCL is low, except at start and stop. Each SCL phase lasts well beyond the two-stage synchronizer and edge detector, so the slave has updated its pull enable before SCL rises again. The bench master holds every quarter bit for eight system clocks. It changes SDA only in the middle of a low phase and raises SCL only after that. The rule that the pull enable changes only while SCL is low therefore tests the controller's timing, not the master's.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam int DATA_W    = 8;
    localparam int HI_W      = 3;
    localparam int SEL_W     = 3;
    localparam int ADDR_W    = HI_W + DATA_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BIT_CNT_W = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MGO,
        ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_WADDR,
        BY_DATA,
        BY_EXTRA
    } byte_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    // Address byte layout: [7] type, [6] S2, [5] S1 (inverted), [4] S0,
    // [3:1] upper array address, [0] direction.
    function automatic logic dev_match(input logic [DATA_W-1:0] b,
                                       input logic [SEL_W-1:0]  strap);
        return b[7] && (b[6] == strap[2]) && (b[5] == ~strap[1])
                    && (b[4] == strap[0]);
    endfunction

    function automatic logic [HI_W-1:0] dev_hi(input logic [DATA_W-1:0] b);
        return b[HI_W:1];
    endfunction

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync
    import tw_eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
        end
    end

    assign evt_o.rise  = scl_s & ~scl_p;
    assign evt_o.fall  = ~scl_s & scl_p;
    assign evt_o.start = scl_s & scl_p & sda_p & ~sda_s;
    assign evt_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
    assign evt_o.sda   = sda_s;

endmodule

// File: rtl/tw_store.sv
module tw_store
    import tw_eeprom_pkg::*;
#(
    parameter int WR_CYCLES = 1000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  wr_req_t           req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    wr_req_t           hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (go_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            hold_q <= req_i;
        end
    end

    // The array changes only in the last cycle of the timed write.
    always_ff @(posedge clk) begin
        if (busy_q && cnt_q == '0) begin
            mem_q[hold_q.addr] <= hold_q.data;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = busy_q;

endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_eeprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt_i,
    input  logic [SEL_W-1:0]  strap_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              commit_o,
    output wr_req_t           req_o,
    output logic              sda_pull_o
);

    localparam logic [BIT_CNT_W-1:0] RX_LAST = BIT_CNT_W'(DATA_W);
    localparam logic [BIT_CNT_W-1:0] TX_LAST = BIT_CNT_W'(DATA_W - 1);

    bus_state_e           state;
    byte_kind_e           kind;
    logic [BIT_CNT_W-1:0] cnt;
    logic [DATA_W-1:0]    sh;
    logic [DATA_W-1:0]    tx_sh;
    logic [HI_W-1:0]      hi_q;
    logic [ADDR_W-1:0]    cur_addr;
    logic                 rd_mode;
    logic                 pend;
    logic                 commit_q;
    logic                 pull_q;
    wr_req_t              req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= BY_DEV;
            cnt      <= '0;
            sh       <= '0;
            tx_sh    <= '0;
            hi_q     <= '0;
            cur_addr <= '0;
            rd_mode  <= 1'b0;
            pend     <= 1'b0;
            commit_q <= 1'b0;
            pull_q   <= 1'b0;
            req_q    <= '0;
        end else if (busy_i) begin
            state    <= ST_IDLE;
            pend     <= 1'b0;
            commit_q <= 1'b0;
            pull_q   <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (evt_i.start) begin
                state  <= ST_RX;
                kind   <= BY_DEV;
                cnt    <= '0;
                pend   <= 1'b0;
                pull_q <= 1'b0;
            end else if (evt_i.stop) begin
                state    <= ST_IDLE;
                pull_q   <= 1'b0;
                commit_q <= pend;
                pend     <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (evt_i.rise && cnt != RX_LAST) begin
                            sh  <= {sh[DATA_W-2:0], evt_i.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt_i.fall && cnt == RX_LAST) begin
                            case (kind)
                                BY_DEV: begin
                                    if (dev_match(sh, strap_i)) begin
                                        state   <= ST_ACK;
                                        pull_q  <= 1'b1;
                                        rd_mode <= sh[0];
                                        if (!sh[0]) hi_q <= dev_hi(sh);
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                BY_WADDR: begin
                                    state    <= ST_ACK;
                                    pull_q   <= 1'b1;
                                    cur_addr <= {hi_q, sh};
                                end
                                BY_DATA: begin
                                    state      <= ST_ACK;
                                    pull_q     <= 1'b1;
                                    req_q.addr <= cur_addr;
                                    req_q.data <= sh;
                                end
                                default: state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt_i.fall) begin
                            cnt    <= '0;
                            pull_q <= 1'b0;
                            state  <= ST_RX;
                            case (kind)
                                BY_DEV: begin
                                    if (rd_mode) begin
                                        state    <= ST_TX;
                                        tx_sh    <= rd_data_i;
                                        pull_q   <= ~rd_data_i[DATA_W-1];
                                        cur_addr <= cur_addr + 1'b1;
                                    end else begin
                                        kind <= BY_WADDR;
                                    end
                                end
                                BY_WADDR: kind <= BY_DATA;
                                default: begin
                                    kind <= BY_EXTRA;
                                    pend <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (evt_i.fall) begin
                            if (cnt == TX_LAST) begin
                                state  <= ST_MACK;
                                pull_q <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                                pull_q <= ~tx_sh[DATA_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt_i.rise) state <= evt_i.sda ? ST_SKIP : ST_MGO;
                    end
                    ST_MGO: begin
                        if (evt_i.fall) begin
                            state    <= ST_TX;
                            cnt      <= '0;
                            tx_sh    <= rd_data_i;
                            pull_q   <= ~rd_data_i[DATA_W-1];
                            cur_addr <= cur_addr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr_o  = cur_addr;
    assign commit_o   = commit_q;
    assign req_o      = req_q;
    assign sda_pull_o = pull_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_eeprom_pkg::*;
#(
    parameter int WR_CYCLES = 1000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] strap_i,
    output logic             sda_pull_o,
    output logic             busy_o
);

    bus_evt_t          evt;
    logic              commit;
    wr_req_t           req;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              busy;

    tw_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    tw_slave_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .strap_i    (strap_i),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .commit_o   (commit),
        .req_o      (req),
        .sda_pull_o (sda_pull_o)
    );

    tw_store #(.WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .go_i      (commit),
        .req_i     (req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

    assign busy_o = busy;

endmodule

// File: rtl/tw_eeprom_checker.sv
module tw_eeprom_checker #(
    parameter int WR_CYCLES = 1000
)(
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_pull_o,
    input logic busy_o
);

    localparam int RUN_W = $clog2(WR_CYCLES + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(WR_CYCLES);

    logic [RUN_W-1:0] run_q;
    logic             rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    always @(posedge clk) begin
        if (rst_d) begin
            AST_RESET_QUIET: assert (!busy_o && !sda_pull_o)  // R11
                else $error("outputs active after reset");
        end
    end

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !sda_pull_o);  // R7

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < RUN_FULL));  // R6

    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == RUN_FULL));  // R6

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);  // R2

endmodule

bind tw_eeprom_slave tw_eeprom_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o)
);

// File: tb/sim_tw_eeprom_slave.sv
`timescale 1ns/1ps
module sim_tw_eeprom_slave;

    localparam int WR = 400;
    localparam int Q  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b011;
    logic       pull;
    logic       busy;
    logic       sda_bus;

    assign sda_bus = m_sda & ~pull;

    always #4 clk = ~clk;

    tw_eeprom_slave #(.WR_CYCLES(WR)) u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .sda_pull_o (pull),
        .busy_o     (busy)
    );

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(logic [2:0] hi, logic rw);
        return {1'b1, strap[2], ~strap[1], strap[0], hi, rw};
    endfunction

    // Bus master primitives
    task automatic wbit(logic b);
        tick(Q); m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic rbit(output logic b);
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0;
    endtask

    task automatic start_c();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic stop_c();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i >= 8 - n; i--) wbit(b[i]);
    endtask

    // Driver: pushes the expected acknowledge bit, then the observed one
    task automatic send_byte(logic [7:0] b, string req, logic exp_ack);
        logic a;
        send_bits(b, 8);
        rbit(a);
        exp_q.push_back('{req, {7'b0, exp_ack}});
        obs_q.push_back({7'b0, a});
    endtask

    task automatic read_byte(string req, logic [7:0] exp, logic mack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        exp_q.push_back('{req, exp});
        obs_q.push_back(v);
        wbit(mack);
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 5000) begin tick(1); k++; end
    endtask

    task automatic write_one(logic [10:0] a, logic [7:0] d);
        start_c();
        send_byte(dev(a[10:8], 1'b0), "R2 address ack", 1'b0);
        send_byte(a[7:0], "R4 word address ack", 1'b0);
        send_byte(d, "R4 data ack", 1'b0);
        stop_c();
        wait_idle();
    endtask

    // Monitor: pops expected items and compares them with what the bus showed
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                item_t      e;
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2 scoreboard actual=%0h expected=none", o);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.req, {24'b0, o}, {24'b0, e.val});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int len;
        int k;
        tick(10);
        rst = 1'b0;
        tick(2);
        chk("R11 pull after reset", {31'b0, pull}, 0);
        chk("R11 busy after reset", {31'b0, busy}, 0);

        // R4 / R5 / R6: byte write, timed cycle length
        start_c();
        send_byte(dev(3'h5, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hA3, "R4 word address ack", 1'b0);
        send_byte(8'h3C, "R4 data ack", 1'b0);
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1;
        k = 0;
        while (!busy && k < 20) begin tick(1); k++; end
        chk("R5 busy after stop", {31'b0, busy}, 1);
        len = 0;
        while (busy && len < 5000) begin tick(1); len++; end
        chk("R6 busy length", len, WR);

        // R7: bus ignored while the write cycle runs
        start_c();
        send_byte(dev(3'h5, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hA4, "R4 word address ack", 1'b0);
        send_byte(8'hC3, "R4 data ack", 1'b0);
        stop_c();
        chk("R7 busy running", {31'b0, busy}, 1);
        start_c();
        send_byte(dev(3'h5, 1'b1), "R7 no ack while busy", 1'b1);
        stop_c();
        wait_idle();

        // R8 / R9: random read, sequential read, master nack
        start_c();
        send_byte(dev(3'h5, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hA3, "R4 word address ack", 1'b0);
        start_c();
        send_byte(dev(3'h0, 1'b1), "R1 repeated start ack", 1'b0);
        read_byte("R8 read first", 8'h3C, 1'b0);
        read_byte("R8 read incremented", 8'hC3, 1'b1);
        read_byte("R9 released after nack", 8'hFF, 1'b1);
        stop_c();
        tick(20);
        chk("R5 no write after address-only", {31'b0, busy}, 0);

        // R2 / R3: mismatching address bytes
        start_c();
        send_byte({1'b1, strap[2], strap[1], strap[0], 4'b0000}, "R2 S1 not inverted", 1'b1);
        send_byte(8'h00, "R3 ignored after mismatch", 1'b1);
        stop_c();
        start_c();
        send_byte({1'b0, strap[2], ~strap[1], strap[0], 4'b0000}, "R3 type bit zero", 1'b1);
        stop_c();
        start_c();
        send_byte({1'b1, strap[2], ~strap[1], ~strap[0], 4'b0000}, "R3 S0 wrong", 1'b1);
        stop_c();

        // R5 / R1: aborts inside a byte
        start_c();
        send_byte(dev(3'h5, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hA3, "R4 word address ack", 1'b0);
        send_bits(8'hFF, 4);
        stop_c();
        tick(20);
        chk("R5 no write on mid-byte stop", {31'b0, busy}, 0);
        start_c();
        send_byte(dev(3'h5, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hA3, "R4 word address ack", 1'b0);
        send_bits(8'h00, 3);
        start_c();
        send_byte(dev(3'h2, 1'b1), "R1 start inside byte", 1'b0);
        read_byte("R5 array unchanged", 8'h3C, 1'b1);
        stop_c();

        // R8: address wrap
        write_one(11'h7FF, 8'h81);
        write_one(11'h000, 8'h18);
        start_c();
        send_byte(dev(3'h7, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'hFF, "R4 word address ack", 1'b0);
        start_c();
        send_byte(dev(3'h0, 1'b1), "R8 read ack", 1'b0);
        read_byte("R8 top location", 8'h81, 1'b0);
        read_byte("R8 wrap to zero", 8'h18, 1'b1);
        stop_c();

        // R10: extra byte not acknowledged, first byte committed
        start_c();
        send_byte(dev(3'h1, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'h23, "R4 word address ack", 1'b0);
        send_byte(8'h55, "R4 data ack", 1'b0);
        send_byte(8'h66, "R10 extra byte nack", 1'b1);
        stop_c();
        chk("R10 commit after extra byte", {31'b0, busy}, 1);
        wait_idle();
        start_c();
        send_byte(dev(3'h1, 1'b0), "R2 address ack", 1'b0);
        send_byte(8'h23, "R4 word address ack", 1'b0);
        start_c();
        send_byte(dev(3'h0, 1'b1), "R8 read ack", 1'b0);
        read_byte("R10 first data kept", 8'h55, 1'b1);
        stop_c();

        tick(50);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule